// File: doc/BRIEF.md
# Serial Receive Status Controller

This block sits between a serial deserializer and a byte-wide host register port. The deserializer hands over each finished character with a valid strobe, a parity-error qualifier and a separate line-break indication. The controller holds the last character in a data register. It keeps four status flags: receive-full, overrun, framing and parity. It raises a one-cycle receive interrupt when a character lands and a level error interrupt when something goes wrong.

New characters are rate-limited by a pacing state machine. It has two states. In `PACE_READY` a strobe is taken. Taking a strobe moves it to `PACE_GAP` when the frame interval is longer than one clock (transition *take*). In `PACE_GAP` an internal down-counter runs, and the machine returns to `PACE_READY` when the count expires (transition *expire*). A character that arrives while the data register is still full is thrown away and flagged as an overrun. The error flags are cleared only by the host writing the status register. When the host has seen errors in a status read and then writes zeros, the error interrupt drops.

Register map (2-bit address): 0 = control (bit 0 receive enable, bit 1 interrupt enable, other bits read 0). 1 = status. 2 = receive data. 3 reads 0x00. Reads are combinational. The read strobe only triggers the side effects of a read.

Top module: `rx_status_ctrl`

## Requirements
- R1: A strobe is taken only while the receive-enable bit (control bit 0) is 1 and the pacer is in `PACE_READY`; a strobe that is not taken changes neither the data register nor the status register and raises no interrupt.
- R2: After a strobe is taken at clock edge t, the next strobe can be taken no earlier than edge t+max(frame_clks,1); a strobe at t+frame_clks is taken.
- R3: A taken character with receive-full clear loads the data register and sets receive-full; if interrupt enable (control bit 1) is 1, rx_irq is high for exactly the one cycle after that edge.
- R4: A taken character with receive-full set is discarded, the data register keeps its value, the overrun flag sets, no rx_irq pulse is produced, and err_irq rises (level) if interrupt enable is 1.
- R5: A loaded character whose parity qualifier is high also sets the parity flag and raises err_irq when interrupt enable is 1.
- R6: A line-break indication sets the framing flag and raises err_irq when interrupt enable is 1, independently of receive enable.
- R7: A host read of address 2 clears receive-full.
- R8: A host write to address 1 replaces status bits [5:3] with write bits [5:3]; err_irq falls on such a write of zeros only if the most recent status read showed an error bit set.
- R9: A host write to the control register with bit 1 at 0 drops err_irq.
- R10: After reset, status reads 0x84, data reads 0x00, control reads 0x00, and both interrupts are low.
- R11: Status layout: bit 6 receive-full, bit 5 overrun, bit 4 framing, bit 3 parity; bits 7 and 2 read 1, bits 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Character-ready strobe from the deserializer |
| rx_byte | input | 8 | Received character |
| rx_perr | input | 1 | Parity-error qualifier for rx_byte |
| rx_break | input | 1 | Line-break indication |
| frame_clks | input | CNT_W | Minimum clocks between taken characters |
| h_addr | input | 2 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (side effects only) |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational on h_addr |
| rx_irq | output | 1 | One-cycle receive interrupt |
| err_irq | output | 1 | Level error interrupt |

## Verification
On every cycle the assertions check the following. A receive pulse lasts one cycle and occurs only with receive-full set. A dropped character leaves the data register intact and sets overrun. The error interrupt never rises without interrupt enable. A data read with no competing load empties the register. No strobe is taken inside a frame interval longer than one clock. Some behaviours can only be shown by the bench's scenarios: the exact edge on which pacing ends, reset values, the status bit layout, and the rule that a clearing write drops the error interrupt only after a status read that showed errors.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PACE_READY = 1'b0,
        PACE_GAP   = 1'b1
    } pace_state_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IE_BIT  = 1;
    localparam int ERR_LSB      = 3;
    localparam int ERR_W        = 3;
    localparam int ERR_IDX_PAR  = 0;
    localparam int ERR_IDX_FRM  = 1;
    localparam int ERR_IDX_OVR  = 2;
endpackage

// File: rtl/rx_pacer.sv
module rx_pacer
    import rx_status_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_seen,
    input  logic [CNT_W-1:0] frame_clks,
    output logic             take
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pace_state_e      state;
    logic [CNT_W-1:0] cnt;

    // state register and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PACE_READY;
            cnt   <= '0;
        end else begin
            unique case (state)
                PACE_READY: begin
                    if (take && frame_clks > ONE) begin
                        state <= PACE_GAP;
                        cnt   <= frame_clks - ONE;
                    end
                end
                PACE_GAP: begin
                    if (cnt <= ONE) state <= PACE_READY;
                    else            cnt   <= cnt - ONE;
                end
                default: state <= PACE_READY;
            endcase
        end
    end

    // outputs
    always_comb begin
        take = byte_seen && (state == PACE_READY);
    end

    // R2: a long interval blocks the very next strobe
    assert_pace_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && frame_clks > ONE) |=> !take);
endmodule

// File: rtl/rx_flag_keeper.sv
module rx_flag_keeper
    import rx_status_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_break,
    input  logic              ie,
    input  logic              ie_off_wr,
    input  logic              stat_wr,
    input  logic [ERR_W-1:0]  stat_wbits,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_q,
    output logic              full,
    output logic [ERR_W-1:0]  err,
    output logic              rxi,
    output logic              eri
);
    logic             load, drop;
    logic [ERR_W-1:0] err_set, snap;
    logic             eri_set, eri_clr;

    always_comb begin
        load    = take && !full;
        drop    = take && full;
        err_set = '0;
        err_set[ERR_IDX_OVR] = drop;
        err_set[ERR_IDX_FRM] = rx_break;
        err_set[ERR_IDX_PAR] = load && rx_perr;
        eri_set = ie && (|err_set);
        eri_clr = ie_off_wr || (stat_wr && (|snap) && (stat_wbits == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full   <= 1'b0;
            err    <= '0;
            snap   <= '0;
            rxi    <= 1'b0;
            eri    <= 1'b0;
        end else begin
            if (load) data_q <= rx_byte;
            if (load)         full <= 1'b1;
            else if (data_rd) full <= 1'b0;
            err  <= (stat_wr ? stat_wbits : err) | err_set;
            if (stat_rd) snap <= err;
            rxi  <= load && ie;
            if (eri_set)      eri <= 1'b1;
            else if (eri_clr) eri <= 1'b0;
        end
    end

    assert_rxi_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rxi |=> !rxi);
    assert_rxi_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rxi |-> full);
    assert_drop_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full) |=> (err[ERR_IDX_OVR] && $stable(data_q)));
    assert_eri_needs_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eri) |-> $past(ie));
    assert_read_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !take) |=> !full);
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
    import rx_status_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_perr,
    input  logic             rx_break,
    input  logic [CNT_W-1:0] frame_clks,
    input  logic [1:0]       h_addr,
    input  logic             h_wr,
    input  logic             h_rd,
    input  logic [7:0]       h_wdata,
    output logic [7:0]       h_rdata,
    output logic             rx_irq,
    output logic             err_irq
);
    logic             en_q, ie_q;
    logic             take;
    logic [7:0]       data_q;
    logic             full;
    logic [ERR_W-1:0] err;
    logic             ctrl_wr, stat_wr, stat_rd, data_rd;
    logic             unused_wbits;

    assign unused_wbits = ^{h_wdata[7:6], h_wdata[2]};

    always_comb begin
        ctrl_wr = h_wr && (reg_sel_e'(h_addr) == REG_CTRL);
        stat_wr = h_wr && (reg_sel_e'(h_addr) == REG_STAT);
        stat_rd = h_rd && (reg_sel_e'(h_addr) == REG_STAT);
        data_rd = h_rd && (reg_sel_e'(h_addr) == REG_DATA);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ie_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q <= h_wdata[CTRL_EN_BIT];
            ie_q <= h_wdata[CTRL_IE_BIT];
        end
    end

    rx_pacer #(.CNT_W(CNT_W)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_seen  (rx_valid && en_q),
        .frame_clks (frame_clks),
        .take       (take)
    );

    rx_flag_keeper #(.DATA_W(8)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .rx_byte    (rx_byte),
        .rx_perr    (rx_perr),
        .rx_break   (rx_break),
        .ie         (ie_q),
        .ie_off_wr  (ctrl_wr && !h_wdata[CTRL_IE_BIT]),
        .stat_wr    (stat_wr),
        .stat_wbits (h_wdata[ERR_LSB +: ERR_W]),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .data_q     (data_q),
        .full       (full),
        .err        (err),
        .rxi        (rx_irq),
        .eri        (err_irq)
    );

    always_comb begin
        unique case (reg_sel_e'(h_addr))
            REG_CTRL: h_rdata = {6'b0, ie_q, en_q};
            REG_STAT: h_rdata = {1'b1, full, err[ERR_IDX_OVR], err[ERR_IDX_FRM],
                                 err[ERR_IDX_PAR], 1'b1, 2'b00};
            REG_DATA: h_rdata = data_q;
            default:  h_rdata = 8'h00;
        endcase
    end

    // R1: nothing is taken while receive is disabled
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !full) |=> !rx_irq);
endmodule

// File: tb/rx_status_ctrl_tb.sv
module rx_status_ctrl_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = 8'h00;
    logic             rx_perr = 1'b0;
    logic             rx_break = 1'b0;
    logic [CNT_W-1:0] frame_clks = CNT_W'(4);
    logic [1:0]       h_addr = 2'd0;
    logic             h_wr = 1'b0;
    logic             h_rd = 1'b0;
    logic [7:0]       h_wdata = 8'h00;
    logic [7:0]       h_rdata;
    logic             rx_irq, err_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rx_status_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_break(rx_break), .frame_clks(frame_clks),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    // {byte, parity qualifier, expected status after load}
    localparam logic [16:0] VEC [0:3] = '{
        {8'h5A, 1'b0, 8'hC4},
        {8'hA5, 1'b1, 8'hCC},
        {8'h00, 1'b0, 8'hC4},
        {8'hFF, 1'b1, 8'hCC}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [7:0] d);
        h_addr = a; h_rd = 1'b1;
        #1 d = h_rdata;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        h_addr = a;
        #1 d = h_rdata;
    endtask

    task automatic send(input logic [7:0] b, input logic p);
        rx_byte = b; rx_perr = p; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0;
    endtask

    task automatic tidy();
        logic [7:0] d;
        step(6);
        hr(2'd1, d);
        hr(2'd2, d);
        hw(2'd1, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R10 / R11 reset state
        peek(2'd1, d); chk("R10 status reset", d, 8'h84);
        peek(2'd2, d); chk("R10 data reset", d, 8'h00);
        peek(2'd0, d); chk("R10 control reset", d, 8'h00);
        chk("R10 irq reset", {6'b0, rx_irq, err_irq}, 8'h00);

        // R1 disabled receive ignores strobes
        hw(2'd0, 8'h02);
        send(8'h77, 1'b1);
        chk("R1 no rxi when disabled", {7'b0, rx_irq}, 8'h00);
        chk("R1 no eri when disabled", {7'b0, err_irq}, 8'h00);
        peek(2'd1, d); chk("R1 status untouched", d, 8'h84);
        peek(2'd2, d); chk("R1 data untouched", d, 8'h00);

        // R3 R5 R7 R8 R11 table walk
        hw(2'd0, 8'h03);
        frame_clks = CNT_W'(4);
        for (int i = 0; i < 4; i++) begin
            step(6);
            send(VEC[i][16:9], VEC[i][8]);
            chk("R3 rxi pulse", {7'b0, rx_irq}, 8'h01);
            chk("R5 eri follows parity", {7'b0, err_irq}, {7'b0, VEC[i][8]});
            step(1);
            chk("R3 rxi one cycle", {7'b0, rx_irq}, 8'h00);
            hr(2'd1, d); chk("R11 status after load", d, VEC[i][7:0]);
            hr(2'd2, d); chk("R3 data", d, VEC[i][16:9]);
            peek(2'd1, d); chk("R7 full cleared", d, VEC[i][7:0] & 8'hBF);
            hr(2'd1, d);
            hw(2'd1, 8'h00);
            chk("R8 eri cleared", {7'b0, err_irq}, 8'h00);
            peek(2'd1, d); chk("R8 flags cleared", d, 8'h84);
        end

        // R3 interrupt disabled: load without pulse
        hw(2'd0, 8'h01);
        step(6);
        send(8'h3C, 1'b0);
        chk("R3 no rxi without enable", {7'b0, rx_irq}, 8'h00);
        peek(2'd1, d); chk("R3 full without enable", d, 8'hC4);
        hr(2'd2, d); chk("R3 data without enable", d, 8'h3C);

        // R4 overrun
        hw(2'd0, 8'h03);
        step(6);
        send(8'h11, 1'b0);
        step(6);
        send(8'h22, 1'b0);
        chk("R4 no rxi on drop", {7'b0, rx_irq}, 8'h00);
        chk("R4 eri on drop", {7'b0, err_irq}, 8'h01);
        peek(2'd1, d); chk("R4 overrun status", d, 8'hE4);
        peek(2'd2, d); chk("R4 data kept", d, 8'h11);
        hr(2'd1, d);
        hw(2'd1, 8'h00);
        chk("R8 eri cleared after overrun", {7'b0, err_irq}, 8'h00);
        peek(2'd1, d); chk("R8 full survives clear", d, 8'hC4);
        tidy();

        // R2 interval boundary, frame_clks = 4
        frame_clks = CNT_W'(4);
        step(6);
        send(8'h41, 1'b0);
        rx_byte = 8'h42; rx_valid = 1'b1;
        step(3);
        peek(2'd1, d); chk("R2 strobes inside gap ignored", d, 8'hC4);
        step(1);
        rx_valid = 1'b0;
        peek(2'd1, d); chk("R2 strobe at interval taken", d, 8'hE4);
        peek(2'd2, d); chk("R2 data is first byte", d, 8'h41);
        tidy();

        // R2 zero interval: back-to-back strobes both taken
        frame_clks = CNT_W'(0);
        step(2);
        rx_byte = 8'h51; rx_valid = 1'b1;
        step(1);
        rx_byte = 8'h52;
        step(1);
        rx_valid = 1'b0;
        peek(2'd1, d); chk("R2 zero interval back to back", d, 8'hE4);
        peek(2'd2, d); chk("R2 zero interval data", d, 8'h51);
        tidy();
        frame_clks = CNT_W'(4);

        // R6 break and R9 control clear
        rx_break = 1'b1;
        step(1);
        rx_break = 1'b0;
        chk("R6 eri on break", {7'b0, err_irq}, 8'h01);
        peek(2'd1, d); chk("R6 framing flag", d, 8'h94);
        hw(2'd0, 8'h01);
        chk("R9 eri dropped by control", {7'b0, err_irq}, 8'h00);
        peek(2'd1, d); chk("R9 flags kept", d, 8'h94);
        hr(2'd1, d);
        hw(2'd1, 8'h00);

        // R8 clear without prior error read keeps eri
        hw(2'd0, 8'h03);
        hr(2'd1, d);
        rx_break = 1'b1;
        step(1);
        rx_break = 1'b0;
        hw(2'd1, 8'h00);
        peek(2'd1, d); chk("R8 flags cleared no snapshot", d, 8'h84);
        chk("R8 eri held without snapshot", {7'b0, err_irq}, 8'h01);
        hw(2'd0, 8'h01);
        hw(2'd0, 8'h03);

        // R8 write replaces error bits
        hw(2'd1, 8'h38);
        peek(2'd1, d); chk("R8 write sets error bits", d, 8'hBC);
        hw(2'd1, 8'h10);
        peek(2'd1, d); chk("R8 write replaces error bits", d, 8'h94);
        hw(2'd1, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule